// File: doc/BRIEF.md
# Snooping Coherence Line-State Controller

This block keeps the coherence state of a direct-mapped set of cache lines for one core in a multi-core system where every cache watches a shared bus. Each line holds a tag and a two-bit state: Modified, Exclusive, Shared or Invalid. The core presents one read or write request at a time and waits for a ready pulse. To serve a request, the controller issues its own bus transactions: a fill read, a read-for-ownership (RFO) that invalidates other copies, or a writeback of a dirty line.

While it does this, it watches bus transactions that come from other cores and answers each one in the same cycle. The answer says whether the line is present here and whether it is dirty here. The controller then demotes or drops the line. When a snooped transaction finds a dirty line, the controller pushes a writeback onto the bus ahead of any request of its own.

All addresses on the ports are line addresses. The low bits of a line address select the line, and the remaining upper bits form the tag. Data storage and memory are outside this block.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid, so no snoop reports a hit, `busReq` is low and `coreReady` is low.
- R2: A local read that misses (the line is Invalid or holds a different tag) issues a bus fill read, `busCmd`=1, at the requested line address. The line is then installed as Shared if `busPeerShared` is high in the acknowledge cycle, and as Exclusive if it is low.
- R3: A local read, whether it hits or is filled, does not complete while `busPeerDirty` is high. It completes only after that input has been seen low.
- R4: A local write to a line held Modified or Exclusive completes without any bus transaction, and leaves the line Modified.
- R5: A local write to a Shared or missing line first issues an RFO, `busCmd`=2, at the requested line address. The write completes only after that RFO is acknowledged, and leaves the line Modified.
- R6: When a miss maps onto a line holding a different tag in Modified, the old line is written back first (`busCmd`=3, at the old line address), and only then is the fill or RFO issued.
- R7: In the same cycle that `snoopValid` is high, `snoopHit` reports that the snooped line is present with a valid state, and `snoopHitMod` reports that it is present as Modified. The snoop codes are read=1, RFO=2 and invalidate=3.
- R8: A snooped read demotes a Modified or Exclusive line to Shared and leaves a Shared line Shared. When the line was Modified, a writeback (`busCmd`=3) of that line is requested in the next cycle and held until it is acknowledged.
- R9: A snooped RFO or invalidate that hits a line leaves it Invalid. When the line was Modified, a writeback of that line is requested first.
- R10: Every accepted core request produces exactly one `coreReady` pulse, one cycle long, in the cycle after the access finishes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| coreReq | input | 1 | Core request strobe, accepted when the controller is idle |
| coreWrite | input | 1 | 1 = write, 0 = read |
| coreAddr | input | LINE_ADDR_W | Requested line address |
| coreReady | output | 1 | One-cycle completion pulse |
| busReq | output | 1 | Bus transaction request, held until acknowledged |
| busCmd | output | 2 | 1 = fill read, 2 = RFO, 3 = writeback |
| busAddr | output | LINE_ADDR_W | Line address of the transaction |
| busAck | input | 1 | Completes the transaction currently presented |
| busPeerShared | input | 1 | Another cache holds the filled line (sampled with `busAck`) |
| busPeerDirty | input | 1 | A peer writeback of the requested line is still pending |
| snoopValid | input | 1 | A transaction from another core is on the bus |
| snoopCmd | input | 2 | 1 = read, 2 = RFO, 3 = invalidate |
| snoopAddr | input | LINE_ADDR_W | Snooped line address |
| snoopHit | output | 1 | The snooped line is present here |
| snoopHitMod | output | 1 | The snooped line is present here as Modified |

## Verification
The bench first runs directed sequences that drive one line through every state. From Exclusive, a silent write separates R4 from R5. Snooping that line then shows the dirty-hit writeback. A write after the snooped read exposes the Shared state, because only Shared forces an RFO. Index conflicts with a dirty occupant show whether the victim writeback comes before the fetch. A held `busPeerDirty` on hits and on fills shows whether the read waits for a peer's writeback. After the directed part, seeded random reads, writes and snoops run over four tags on eight indices, with random `busPeerShared` and `busPeerDirty`. A bench model of the tags and states predicts every bus command, bus address and snoop response.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_E = 2'd2,
    ST_M = 2'd3
  } lineState_t;

  typedef enum logic [1:0] {
    BC_NONE = 2'd0,
    BC_READ = 2'd1,
    BC_RFO  = 2'd2,
    BC_WB   = 2'd3
  } busCmd_t;

  typedef enum logic [1:0] {
    SC_NONE = 2'd0,
    SC_READ = 2'd1,
    SC_RFO  = 2'd2,
    SC_INV  = 2'd3
  } snoopCmd_t;

  // Strobes from the control FSM to the line store
  typedef struct packed {
    logic       captureReq;  // latch the core request
    logic       setState;    // write tag+state of the request's index
    lineState_t newState;    // state written by setState
    logic       addrVictim;  // bus address comes from the resident (old) tag
  } ctlStrobe_t;

endpackage

// File: rtl/mesi_line_store.sv
module mesi_line_store
  import mesi_pkg::*;
#(
  parameter int LINE_ADDR_W = 10,
  parameter int IDX_W       = 3
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctlStrobe_t             strobe,
  input  logic [LINE_ADDR_W-1:0] coreAddr,
  input  logic                   coreWrite,
  input  logic                   snoopValid,
  input  logic [1:0]             snoopCmd,
  input  logic [LINE_ADDR_W-1:0] snoopAddr,
  input  logic                   busAck,
  output logic                   reqHit,
  output lineState_t             reqState,
  output logic                   victimDirty,
  output logic                   reqWrite,
  output logic                   flushPending,
  output logic [LINE_ADDR_W-1:0] busAddr,
  output logic                   snoopHit,
  output logic                   snoopHitMod
);

  localparam int TAG_W = LINE_ADDR_W - IDX_W;
  localparam int LINES = 1 << IDX_W;

  logic [TAG_W-1:0]       tagArr [LINES];
  lineState_t             stArr  [LINES];

  logic [TAG_W-1:0]       reqTag;
  logic [IDX_W-1:0]       reqIdx;
  logic                   reqWriteR;
  logic                   flushPendR;
  logic [LINE_ADDR_W-1:0] flushAddrR;
  logic [IDX_W-1:0]       lastSnpIdx;

  // Request-side lookup
  logic [TAG_W-1:0] curTag;
  lineState_t       curSt;

  always_comb begin
    curTag      = tagArr[reqIdx];
    curSt       = stArr[reqIdx];
    reqHit      = (curSt != ST_I) && (curTag == reqTag);
    reqState    = curSt;
    victimDirty = (curSt == ST_M) && (curTag != reqTag);
  end

  assign reqWrite     = reqWriteR;
  assign flushPending = flushPendR;

  // Snoop-side lookup
  snoopCmd_t        snCmd;
  logic [TAG_W-1:0] sTag;
  logic [IDX_W-1:0] sIdx;
  logic             snActive;
  logic             snHit;
  logic             snHitMod;
  lineState_t       snNext;
  logic             flushSet;

  always_comb begin
    snCmd    = snoopCmd_t'(snoopCmd);
    sTag     = snoopAddr[LINE_ADDR_W-1 -: TAG_W];
    sIdx     = snoopAddr[IDX_W-1:0];
    snActive = snoopValid && (snCmd != SC_NONE);
    snHit    = snActive && (stArr[sIdx] != ST_I) && (tagArr[sIdx] == sTag);
    snHitMod = snHit && (stArr[sIdx] == ST_M);
    snNext   = (snCmd == SC_READ) ? ST_S : ST_I;
    flushSet = snHitMod && !flushPendR;
  end

  assign snoopHit    = snHit;
  assign snoopHitMod = snHitMod;

  always_comb begin
    if (flushPendR)             busAddr = flushAddrR;
    else if (strobe.addrVictim) busAddr = {curTag, reqIdx};
    else                        busAddr = {reqTag, reqIdx};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < LINES; i++) begin
        tagArr[i] <= '0;
        stArr[i]  <= ST_I;
      end
      reqTag     <= '0;
      reqIdx     <= '0;
      reqWriteR  <= 1'b0;
      flushPendR <= 1'b0;
      flushAddrR <= '0;
      lastSnpIdx <= '0;
    end else begin
      lastSnpIdx <= sIdx;
      if (strobe.captureReq) begin
        reqTag    <= coreAddr[LINE_ADDR_W-1 -: TAG_W];
        reqIdx    <= coreAddr[IDX_W-1:0];
        reqWriteR <= coreWrite;
      end
      if (snHit) stArr[sIdx] <= snNext;
      // local install takes priority over a same-cycle snoop update
      if (strobe.setState) begin
        tagArr[reqIdx] <= reqTag;
        stArr[reqIdx]  <= strobe.newState;
      end
      if (flushPendR && busAck) flushPendR <= 1'b0;
      if (flushSet) begin
        flushPendR <= 1'b1;
        flushAddrR <= snoopAddr;
      end
    end
  end

  // R8: a snooped read that hits leaves the line Shared
  a_r8_read_shares: assert property (@(posedge clk) disable iff (!rstN)
    (snHit && snCmd == SC_READ && !strobe.setState) |=> stArr[lastSnpIdx] == ST_S);

  // R9: a snooped RFO or invalidate that hits leaves the line Invalid
  a_r9_own_clears: assert property (@(posedge clk) disable iff (!rstN)
    (snHit && snCmd != SC_READ && !strobe.setState) |=> stArr[lastSnpIdx] == ST_I);

  // R8: a pending snoop writeback stays put until acknowledged
  a_r8_flush_held: assert property (@(posedge clk) disable iff (!rstN)
    (flushPendR && !busAck) |=> (flushPendR && $stable(flushAddrR)));

endmodule

// File: rtl/mesi_line_fsm.sv
module mesi_line_fsm
  import mesi_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       coreReq,
  input  logic       reqHit,
  input  lineState_t reqState,
  input  logic       victimDirty,
  input  logic       reqWrite,
  input  logic       flushPending,
  input  logic       busAck,
  input  logic       busPeerShared,
  input  logic       busPeerDirty,
  input  logic       snoopValid,
  output ctlStrobe_t strobe,
  output logic       busReq,
  output busCmd_t    busCmd,
  output logic       coreReady
);

  typedef enum logic [2:0] {
    F_IDLE   = 3'd0,
    F_LOOKUP = 3'd1,
    F_BUS    = 3'd2,
    F_WAIT   = 3'd3,
    F_DONE   = 3'd4
  } fsm_t;

  fsm_t    fsm, fsmNext;
  busCmd_t curCmd, curCmdNext;
  busCmd_t afterCmd, afterCmdNext;
  logic    localAck;

  assign localAck = busAck && !flushPending;

  always_comb begin
    strobe       = '0;
    strobe.newState = ST_I;
    fsmNext      = fsm;
    curCmdNext   = curCmd;
    afterCmdNext = afterCmd;
    case (fsm)
      F_IDLE: begin
        if (coreReq) begin
          strobe.captureReq = 1'b1;
          fsmNext = F_LOOKUP;
        end
      end
      F_LOOKUP: begin
        // a snoop in this cycle may change the line: decide next cycle
        if (!snoopValid) begin
          if (reqHit && !reqWrite) begin
            fsmNext = busPeerDirty ? F_WAIT : F_DONE;
          end else if (reqHit && (reqState == ST_M || reqState == ST_E)) begin
            strobe.setState = 1'b1;
            strobe.newState = ST_M;
            fsmNext = F_DONE;
          end else if (reqHit) begin
            curCmdNext = BC_RFO;
            fsmNext = F_BUS;
          end else if (victimDirty) begin
            curCmdNext   = BC_WB;
            afterCmdNext = reqWrite ? BC_RFO : BC_READ;
            fsmNext = F_BUS;
          end else begin
            curCmdNext = reqWrite ? BC_RFO : BC_READ;
            fsmNext = F_BUS;
          end
        end
      end
      F_BUS: begin
        strobe.addrVictim = (curCmd == BC_WB);
        if (localAck) begin
          case (curCmd)
            BC_WB: begin
              strobe.setState = 1'b1;
              strobe.newState = ST_I;
              curCmdNext = afterCmd;
            end
            BC_READ: begin
              strobe.setState = 1'b1;
              strobe.newState = busPeerShared ? ST_S : ST_E;
              fsmNext = busPeerDirty ? F_WAIT : F_DONE;
            end
            BC_RFO: begin
              strobe.setState = 1'b1;
              strobe.newState = ST_M;
              fsmNext = F_DONE;
            end
            default: fsmNext = F_DONE;
          endcase
        end
      end
      F_WAIT: begin
        if (!busPeerDirty) fsmNext = F_DONE;
      end
      F_DONE: fsmNext = F_IDLE;
      default: fsmNext = F_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fsm      <= F_IDLE;
      curCmd   <= BC_NONE;
      afterCmd <= BC_NONE;
    end else begin
      fsm      <= fsmNext;
      curCmd   <= curCmdNext;
      afterCmd <= afterCmdNext;
    end
  end

  // snoop writebacks take the bus ahead of local transactions
  always_comb begin
    busReq    = flushPending || (fsm == F_BUS);
    if (flushPending)      busCmd = BC_WB;
    else if (fsm == F_BUS) busCmd = curCmd;
    else                   busCmd = BC_NONE;
    coreReady = (fsm == F_DONE);
  end

  // R10: ready is a single-cycle pulse
  a_r10_ready_single: assert property (@(posedge clk) disable iff (!rstN)
    coreReady |=> !coreReady);

  // R3: a read never completes on an edge where the peer writeback was pending
  a_r3_read_waits: assert property (@(posedge clk) disable iff (!rstN)
    (coreReady && !reqWrite) |-> !$past(busPeerDirty));

  // R8: a pending snoop writeback is what the bus sees
  a_r8_flush_first: assert property (@(posedge clk) disable iff (!rstN)
    flushPending |-> (busReq && busCmd == BC_WB));

endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
  import mesi_pkg::*;
#(
  parameter int LINE_ADDR_W = 10,
  parameter int IDX_W       = 3
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   coreReq,
  input  logic                   coreWrite,
  input  logic [LINE_ADDR_W-1:0] coreAddr,
  output logic                   coreReady,
  output logic                   busReq,
  output logic [1:0]             busCmd,
  output logic [LINE_ADDR_W-1:0] busAddr,
  input  logic                   busAck,
  input  logic                   busPeerShared,
  input  logic                   busPeerDirty,
  input  logic                   snoopValid,
  input  logic [1:0]             snoopCmd,
  input  logic [LINE_ADDR_W-1:0] snoopAddr,
  output logic                   snoopHit,
  output logic                   snoopHitMod
);

  ctlStrobe_t strobe;
  logic       reqHit;
  lineState_t reqState;
  logic       victimDirty;
  logic       reqWrite;
  logic       flushPending;
  busCmd_t    busCmdE;

  mesi_line_store #(
    .LINE_ADDR_W(LINE_ADDR_W),
    .IDX_W      (IDX_W)
  ) u_store (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .coreAddr    (coreAddr),
    .coreWrite   (coreWrite),
    .snoopValid  (snoopValid),
    .snoopCmd    (snoopCmd),
    .snoopAddr   (snoopAddr),
    .busAck      (busAck),
    .reqHit      (reqHit),
    .reqState    (reqState),
    .victimDirty (victimDirty),
    .reqWrite    (reqWrite),
    .flushPending(flushPending),
    .busAddr     (busAddr),
    .snoopHit    (snoopHit),
    .snoopHitMod (snoopHitMod)
  );

  mesi_line_fsm u_fsm (
    .clk          (clk),
    .rstN         (rstN),
    .coreReq      (coreReq),
    .reqHit       (reqHit),
    .reqState     (reqState),
    .victimDirty  (victimDirty),
    .reqWrite     (reqWrite),
    .flushPending (flushPending),
    .busAck       (busAck),
    .busPeerShared(busPeerShared),
    .busPeerDirty (busPeerDirty),
    .snoopValid   (snoopValid),
    .strobe       (strobe),
    .busReq       (busReq),
    .busCmd       (busCmdE),
    .coreReady    (coreReady)
  );

  assign busCmd = busCmdE;

endmodule

// File: tb/mesi_line_ctrl_bench.sv
`timescale 1ns/1ps
module mesi_line_ctrl_bench;
  import mesi_pkg::*;

  localparam int AW = 10;
  localparam int IW = 3;
  localparam int TW = AW - IW;
  localparam int NL = 1 << IW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          coreReq = 1'b0, coreWrite = 1'b0;
  logic [AW-1:0] coreAddr = '0;
  logic          coreReady;
  logic          busReq;
  logic [1:0]    busCmd;
  logic [AW-1:0] busAddr;
  logic          busAck = 1'b0, busPeerShared = 1'b0, busPeerDirty = 1'b0;
  logic          snoopValid = 1'b0;
  logic [1:0]    snoopCmd = 2'd0;
  logic [AW-1:0] snoopAddr = '0;
  logic          snoopHit, snoopHitMod;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  lineState_t    mSt  [NL];
  logic [TW-1:0] mTag [NL];

  always #10 clk = ~clk;

  mesi_line_ctrl #(.LINE_ADDR_W(AW), .IDX_W(IW)) u_mesi_line_ctrl (
    .clk(clk), .rstN(rstN),
    .coreReq(coreReq), .coreWrite(coreWrite), .coreAddr(coreAddr), .coreReady(coreReady),
    .busReq(busReq), .busCmd(busCmd), .busAddr(busAddr), .busAck(busAck),
    .busPeerShared(busPeerShared), .busPeerDirty(busPeerDirty),
    .snoopValid(snoopValid), .snoopCmd(snoopCmd), .snoopAddr(snoopAddr),
    .snoopHit(snoopHit), .snoopHitMod(snoopHitMod)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic string cmdReq(input logic [1:0] c);
    if (c == 2'd1) return "R2";
    if (c == 2'd2) return "R5";
    return "R6";
  endfunction

  // One core access with a predicted bus command sequence
  task automatic access(input bit wr, input logic [TW-1:0] tg, input logic [IW-1:0] ix,
                        input bit shared, input int dirty);
    logic [1:0]    expCmd [2];
    logic [AW-1:0] expAdr [2];
    int  nExp = 0;
    int  nSeen = 0;
    int  dirtyLeft;
    bit  prevDirty;
    bit  got = 1'b0;
    bit  hit;
    hit = (mSt[ix] != ST_I) && (mTag[ix] == tg);
    if (!(hit && !wr) && !(hit && wr && (mSt[ix] == ST_M || mSt[ix] == ST_E))) begin
      if (hit) begin
        expCmd[0] = 2'd2; expAdr[0] = {tg, ix}; nExp = 1;
      end else begin
        if (mSt[ix] == ST_M) begin
          expCmd[nExp] = 2'd3; expAdr[nExp] = {mTag[ix], ix}; nExp++;
        end
        expCmd[nExp] = wr ? 2'd2 : 2'd1; expAdr[nExp] = {tg, ix}; nExp++;
      end
    end
    @(negedge clk);
    coreReq = 1'b1; coreWrite = wr; coreAddr = {tg, ix};
    busPeerShared = shared;
    dirtyLeft = wr ? 0 : dirty;
    busPeerDirty = (dirtyLeft > 0);
    prevDirty = busPeerDirty;
    for (int c = 0; c < 100 && !got; c++) begin
      @(negedge clk);
      coreReq = 1'b0;
      busAck = 1'b0;
      if (coreReady) begin
        got = 1'b1;
        if (!wr) check(!prevDirty, "R3", "read completed during peer writeback", 32'(prevDirty), 0);
      end
      if (busReq) begin
        if (nSeen < nExp) begin
          check(busCmd == expCmd[nSeen], cmdReq(expCmd[nSeen]), "bus command", 32'(busCmd), 32'(expCmd[nSeen]));
          check(busAddr == expAdr[nSeen], cmdReq(expCmd[nSeen]), "bus address", 32'(busAddr), 32'(expAdr[nSeen]));
        end else begin
          check(1'b0, wr ? "R4" : "R2", "unexpected bus request", 32'(busCmd), 0);
        end
        nSeen++;
        busAck = 1'b1;
      end
      if (dirtyLeft > 0) dirtyLeft--;
      busPeerDirty = (dirtyLeft > 0);
      prevDirty = busPeerDirty;
    end
    busAck = 1'b0;
    busPeerDirty = 1'b0;
    check(got, "R10", "ready pulse seen", 32'(got), 1);
    check(nSeen == nExp, wr ? "R5" : "R2", "bus transaction count", 32'(nSeen), 32'(nExp));
    @(negedge clk);
    check(!coreReady, "R10", "ready lasts one cycle", 32'(coreReady), 0);
    if (wr) begin
      mSt[ix] = ST_M; mTag[ix] = tg;
    end else if (!hit) begin
      mSt[ix] = shared ? ST_S : ST_E; mTag[ix] = tg;
    end
  endtask

  // One snooped transaction, with the expected response and writeback
  task automatic snoop(input logic [1:0] cmd, input logic [TW-1:0] tg, input logic [IW-1:0] ix);
    bit expHit, expMod;
    string rq;
    expHit = (mSt[ix] != ST_I) && (mTag[ix] == tg);
    expMod = expHit && (mSt[ix] == ST_M);
    rq = (cmd == 2'd1) ? "R8" : "R9";
    @(negedge clk);
    snoopValid = 1'b1; snoopCmd = cmd; snoopAddr = {tg, ix};
    #1;
    check(snoopHit == expHit, "R7", "snoop hit", 32'(snoopHit), 32'(expHit));
    check(snoopHitMod == expMod, "R7", "snoop modified hit", 32'(snoopHitMod), 32'(expMod));
    @(negedge clk);
    snoopValid = 1'b0; snoopCmd = 2'd0;
    if (expMod) begin
      check(busReq && busCmd == 2'd3, rq, "snoop writeback request", {30'd0, busCmd}, 3);
      check(busAddr == {tg, ix}, rq, "snoop writeback address", 32'(busAddr), 32'({tg, ix}));
      busAck = 1'b1;
      @(negedge clk);
      busAck = 1'b0;
    end
    check(!busReq, rq, "bus idle after snoop", 32'(busReq), 0);
    if (expHit) mSt[ix] = (cmd == 2'd1) ? ST_S : ST_I;
  endtask

  initial begin
    void'($urandom(32'd7319));
    for (int i = 0; i < NL; i++) begin
      mSt[i] = ST_I; mTag[i] = '0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(!coreReady, "R1", "ready after reset", 32'(coreReady), 0);
    check(!busReq, "R1", "bus request after reset", 32'(busReq), 0);
    for (int i = 0; i < NL; i++) snoop(2'd1, TW'(0), IW'(i));

    // R2/R4/R8: exclusive fill, silent write, snooped read with writeback
    access(1'b0, TW'(1), IW'(0), 1'b0, 0);
    access(1'b1, TW'(1), IW'(0), 1'b0, 0);
    snoop(2'd1, TW'(1), IW'(0));
    // R5: write to Shared needs RFO; R9: snooped RFO on Modified
    access(1'b1, TW'(1), IW'(0), 1'b0, 0);
    snoop(2'd2, TW'(1), IW'(0));
    // R2 shared fill, R9 invalidate on Shared
    access(1'b0, TW'(2), IW'(1), 1'b1, 0);
    snoop(2'd1, TW'(2), IW'(1));
    snoop(2'd3, TW'(2), IW'(1));
    // R3: peer writeback pending on a fill and on a hit
    access(1'b0, TW'(2), IW'(1), 1'b1, 4);
    access(1'b0, TW'(2), IW'(1), 1'b0, 3);
    // R6: dirty victim written back before the fetch
    access(1'b1, TW'(3), IW'(2), 1'b0, 0);
    access(1'b0, TW'(0), IW'(2), 1'b0, 0);
    access(1'b1, TW'(3), IW'(2), 1'b0, 0);
    access(1'b1, TW'(1), IW'(2), 1'b0, 0);
    // R8: Exclusive demoted by a snooped read, then a write needs RFO
    access(1'b0, TW'(0), IW'(3), 1'b0, 0);
    snoop(2'd1, TW'(0), IW'(3));
    access(1'b1, TW'(0), IW'(3), 1'b0, 0);
    // R9: Exclusive dropped by snooped invalidate
    access(1'b0, TW'(1), IW'(4), 1'b0, 0);
    snoop(2'd3, TW'(1), IW'(4));
    access(1'b1, TW'(1), IW'(4), 1'b0, 0);

    for (int k = 0; k < 400; k++) begin
      int r;
      logic [TW-1:0] tg;
      logic [IW-1:0] ix;
      r  = $urandom_range(0, 9);
      tg = TW'($urandom_range(0, 3));
      ix = IW'($urandom_range(0, NL - 1));
      if (r < 4)
        access(1'b0, tg, ix, 1'($urandom_range(0, 1)),
               ($urandom_range(0, 3) == 0) ? $urandom_range(1, 3) : 0);
      else if (r < 7)
        access(1'b1, tg, ix, 1'b0, 0);
      else
        snoop(2'($urandom_range(1, 3)), tg, ix);
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL R10 watchdog expired actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

endmodule